// File: doc/BRIEF.md
# Gated-Clock Parallel-Load Shift Register

This block is an eight-stage parallel-in, serial-out shift register for a fully synchronous design. A free-running system clock samples every input. Two shift-clock pins feed a two-flop synchroniser each. Their synchronised levels are ORed, which is the inverse of the NOR that gates the clock. A 0-to-1 step of that combined level is a shift edge. Because the pins are combined this way, either pin held high stops the other one from clocking the register.

The active-low `load_n` input is level sensitive. While it is low, the parallel word is copied into the stages on every system clock, whatever the clock pins are doing. While it is high, each detected shift edge moves the serial input into the first stage and every stage passes its value to the next one. The last stage is available on two outputs, true and inverted. A synchronous active-high reset clears the stages and the edge-detection history.

Top module: `pgs_shift_reg`

## Requirements
- R1: After reset, every stage holds 0, so `q_last` is 0 and `q_last_n` is 1.
- R2: While `load_n` is 0 at a system clock edge, that edge copies `par_in` into the stages, with `par_in[0]` going to the first stage and `par_in[7]` going to the last stage. The new last stage is seen on `q_last` after that single edge.
- R3: A load wins over shifting. Clock pin activity while `load_n` is 0 causes no shift, either then or after `load_n` returns high.
- R4: With `load_n` high, a rising step of `ck_a | ck_b` shifts the register once. The first stage takes `ser_in` and each later stage takes the old value of the stage before it, so a loaded word leaves on `q_last` as `par_in[7]` first and `par_in[0]` last.
- R5: While either clock pin is held high, pulses on the other pin cause no shift.
- R6: With `load_n` high and no rising step of the combined clock level, every stage keeps its value.
- R7: `q_last_n` is always the inverse of `q_last`.
- R8: A shift takes effect at the third system clock edge after the clock pin rises. Two edges pass through the synchroniser and one through the edge detector, so after two edges `q_last` is still unchanged.
- R9: `ser_in` is sampled at the system clock edge that performs the shift. It does not go through a synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| load_n | input | 1 | Active-low parallel load; when high, shifting is allowed |
| ck_a | input | 1 | Shift clock pin; when held high it blocks `ck_b` |
| ck_b | input | 1 | Shift clock pin; when held high it blocks `ck_a` |
| par_in | input | 8 | Parallel word; bit 0 goes to the first stage, bit 7 to the last |
| ser_in | input | 1 | Serial data shifted into the first stage |
| q_last | output | 1 | Last stage |
| q_last_n | output | 1 | Inverse of the last stage |

## Verification
A load appears on `q_last` one system clock edge after `load_n` is driven low. A shift appears three edges after a clock pin rises. The bench drives every input on the falling edge of the system clock. It keeps each pin pulse high for four cycles and low for four, and samples only on falling edges after those counts, so each result is read after it is due and before the next stimulus. The latency is checked directly: `q_last` is read after two edges, when it must still be unchanged, and after the third, when the shifted value must be present. Inhibit and load-priority cases are checked at the ports by shifting the whole register out afterwards and comparing every bit with the bench model.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

    localparam int STAGES      = 8;
    localparam int SYNC_DEPTH  = 2;

    typedef logic [STAGES-1:0] stage_vec_t;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'd0,
        OP_LOAD  = 2'd1,
        OP_SHIFT = 2'd2
    } stage_op_e;

    // Load is level sensitive and has priority over a detected shift edge.
    function automatic stage_op_e pick_op(input logic load_n, input logic edge_seen);
        if (!load_n)
            return OP_LOAD;
        else if (edge_seen)
            return OP_SHIFT;
        else
            return OP_HOLD;
    endfunction

endpackage

// File: rtl/pgs_clk_gate.sv
module pgs_clk_gate #(
    parameter int SYNC_DEPTH = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ck_a,
    input  logic ck_b,
    output logic shift_edge
);
    localparam int MSB = SYNC_DEPTH - 1;

    logic [MSB:0] sync_a;
    logic [MSB:0] sync_b;
    logic         lvl_prev;
    logic         lvl_now;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_a   <= '0;
            sync_b   <= '0;
            lvl_prev <= 1'b0;
        end else begin
            sync_a   <= {sync_a[MSB-1:0], ck_a};
            sync_b   <= {sync_b[MSB-1:0], ck_b};
            lvl_prev <= lvl_now;
        end
    end

    // Inverse of the NOR gate: a high on either pin holds the combined level high.
    assign lvl_now    = sync_a[MSB] | sync_b[MSB];
    assign shift_edge = lvl_now & ~lvl_prev;

    // R5
    a_high_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_a[MSB] && $past(sync_a[MSB])) |-> !shift_edge);

    // R5
    b_high_blocks_chk: assert property (@(posedge clk) disable iff (rst)
        (sync_b[MSB] && $past(sync_b[MSB])) |-> !shift_edge);

endmodule

// File: rtl/pgs_stage_reg.sv
module pgs_stage_reg
    import pgs_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  stage_op_e        op,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    output logic [WIDTH-1:0] stages
);
    logic [WIDTH-1:0] nxt;

    always_comb begin
        nxt = stages;
        case (op)
            OP_LOAD:  nxt = par_in;
            OP_SHIFT: nxt = {stages[WIDTH-2:0], ser_in};
            default:  nxt = stages;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            stages <= '0;
        else
            stages <= nxt;
    end

    // R2
    load_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LOAD) |=> (stages == $past(par_in)));

    // R4
    shift_move_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SHIFT) |=> (stages[WIDTH-1:1] == $past(stages[WIDTH-2:0])));

    // R9
    serial_take_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_SHIFT) |=> (stages[0] == $past(ser_in)));

    // R6
    hold_still_chk: assert property (@(posedge clk) disable iff (rst)
        (op == OP_HOLD) |=> $stable(stages));

endmodule

// File: rtl/pgs_shift_reg.sv
module pgs_shift_reg
    import pgs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_n,
    input  logic              ck_a,
    input  logic              ck_b,
    input  logic [STAGES-1:0] par_in,
    input  logic              ser_in,
    output logic              q_last,
    output logic              q_last_n
);
    logic       shift_edge;
    stage_op_e  op;
    stage_vec_t stages;

    pgs_clk_gate #(
        .SYNC_DEPTH (SYNC_DEPTH)
    ) u_clk_gate (
        .clk        (clk),
        .rst        (rst),
        .ck_a       (ck_a),
        .ck_b       (ck_b),
        .shift_edge (shift_edge)
    );

    assign op = pick_op(load_n, shift_edge);

    pgs_stage_reg #(
        .WIDTH (STAGES)
    ) u_stages (
        .clk    (clk),
        .rst    (rst),
        .op     (op),
        .par_in (par_in),
        .ser_in (ser_in),
        .stages (stages)
    );

    assign q_last   = stages[STAGES-1];
    assign q_last_n = ~stages[STAGES-1];

    // R3
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (!load_n && shift_edge) |=> (q_last == $past(par_in[STAGES-1])));

endmodule

// File: tb/test_pgs_shift_reg.sv
module test_pgs_shift_reg;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         load_n = 1'b1;
    logic         ck_a = 1'b0;
    logic         ck_b = 1'b0;
    logic [W-1:0] par_in = '0;
    logic         ser_in = 1'b0;
    logic         q_last;
    logic         q_last_n;

    int checks = 0;
    int failures = 0;
    logic [W-1:0] model = '0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pgs_shift_reg i_pgs_shift_reg (
        .clk(clk), .rst(rst), .load_n(load_n), .ck_a(ck_a), .ck_b(ck_b),
        .par_in(par_in), .ser_in(ser_in), .q_last(q_last), .q_last_n(q_last_n)
    );

    function automatic logic [W-1:0] shifted(input logic [W-1:0] v, input logic s);
        return {v[W-2:0], s};
    endfunction

    task automatic chk(input string req, input logic got, input logic exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s q_last got=%0b exp=%0b", req, got, exp);
        end
        checks++;
        if (q_last_n !== ~got) begin
            failures++;
            $display("FAIL R7 q_last_n got=%0b exp=%0b", q_last_n, ~got);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_pin(input int pin, input logic v);
        if (pin == 0) ck_a = v; else ck_b = v;
    endtask

    // One full pulse on a clock pin; shifts unless blocked.
    task automatic pulse(input int pin, input logic s, input bit expect_shift, input string req);
        ser_in = s;
        set_pin(pin, 1'b1);
        wait_n(4);
        set_pin(pin, 1'b0);
        wait_n(4);
        if (expect_shift) model = shifted(model, s);
        chk(req, q_last, model[W-1]);
    endtask

    task automatic do_load(input logic [W-1:0] v);
        load_n = 1'b0;
        par_in = v;
        wait_n(1);
        model = v;
        chk("R2", q_last, model[W-1]);
        load_n = 1'b1;
        par_in = ~v;
    endtask

    // Shift the whole register out and compare each bit with the model.
    task automatic drain(input string req);
        for (int i = 0; i < W; i++)
            pulse(i % 2, 1'($urandom_range(0, 1)), 1'b1, req);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        wait_n(3);
        rst = 1'b0;
        wait_n(1);
        // R1 reset state, then all stages zero
        chk("R1", q_last, 1'b0);
        drain("R1");

        // R2 / R4 load then eight shifts showing h..a
        do_load(8'b1011_0010);
        wait_n(3);
        chk("R6", q_last, model[W-1]);
        drain("R4");

        // R8 latency: unchanged after two edges, shifted after the third
        do_load(8'h80);
        ser_in = 1'b0;
        ck_a = 1'b1;
        wait_n(2);
        chk("R8", q_last, 1'b1);
        wait_n(1);
        chk("R8", q_last, 1'b0);
        model = shifted(model, 1'b0);
        wait_n(1);
        ck_a = 1'b0;
        wait_n(4);

        // R5 each pin inhibits the other
        for (int p = 0; p < 2; p++) begin
            load_n = 1'b0;
            par_in = 8'h5A ^ W'(p * 8'hFF);
            set_pin(p, 1'b1);
            wait_n(4);
            model = par_in;
            load_n = 1'b1;
            wait_n(1);
            pulse(1 - p, 1'b1, 1'b0, "R5");
            pulse(1 - p, 1'b0, 1'b0, "R5");
            set_pin(p, 1'b0);
            wait_n(4);
            chk("R5", q_last, model[W-1]);
            drain("R5");
        end

        // R3 load wins over clock activity during load
        load_n = 1'b0;
        par_in = 8'hC3;
        ser_in = 1'b1;
        ck_b = 1'b1;
        wait_n(4);
        ck_b = 1'b0;
        wait_n(4);
        model = 8'hC3;
        load_n = 1'b1;
        wait_n(1);
        chk("R3", q_last, model[W-1]);
        drain("R3");

        // R9 random serial data and mixed random operations
        for (int k = 0; k < 60; k++) begin
            case ($urandom_range(0, 3))
                0: do_load(W'($urandom));
                1, 2: pulse($urandom_range(0, 1), 1'($urandom_range(0, 1)), 1'b1, "R9");
                default: begin
                    wait_n($urandom_range(1, 5));
                    chk("R6", q_last, model[W-1]);
                end
            endcase
        end
        drain("R4");

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                failures++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule